// File: doc/BRIEF.md
# Repeating Alarm Match Unit

This block keeps a four-field alarm setting (seconds, minutes, hours and day of month) and compares it with a BCD calendar time from an external timekeeper. The compare runs only on a one-cycle strobe that the timekeeper raises once per second. When the selected fields agree, the block raises an interrupt for exactly one clock cycle.

Software writes the alarm fields through a small byte-wide register port. Each field keeps its BCD value in the low bits. Bit 7 of each field is a "don't care" flag. The combination of these four flags selects how often the alarm repeats: monthly, daily, hourly, every minute or every second. A write whose BCD value is not a legal value for its field is dropped, and the field keeps its previous contents.

Top module: `alarm_match`

## Requirements
- R1: After reset, all four alarm fields read back as 0x00 and `irq` is low.
- R2: The field addresses are 0 for seconds, 1 for minutes, 2 for hours and 3 for date. An accepted write stores the whole byte, including bit 7. That byte reads back on `reg_rdata` from the clock edge after the write.
- R3: A seconds or minutes write is accepted only when bits 6:0 form valid BCD in the range 00..59. Valid BCD means the units nibble is at most 9. Any other write leaves the field unchanged.
- R4: An hours write is accepted only when bits 5:0 form valid BCD in the range 00..23. Any other write leaves the field unchanged.
- R5: A date write is accepted only when bits 5:0 form valid BCD in the range 01..31. Any other write leaves the field unchanged.
- R6: When no flag is set, a strobe raises `irq` only if all four fields match the current time. Fields are compared on bits 6:0 for seconds and minutes, and on bits 5:0 for hours and date.
- R7: When only the date flag is set, a strobe raises `irq` if seconds, minutes and hours match. The date is not compared.
- R8: When the date and hour flags are set and the other two are clear, a strobe raises `irq` if seconds and minutes match.
- R9: When the date, hour and minute flags are set and the seconds flag is clear, a strobe raises `irq` if seconds match.
- R10: Any other flag combination raises `irq` on every strobe.
- R11: `irq` goes high only in the cycle after a cycle with `tick` high. It is a single-cycle pulse for each matching strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe, once per second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current day of month, BCD |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Field select: 0 sec, 1 min, 2 hour, 3 date |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected field |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
The hardest cases are the intermediate repeat rates. Reaching them takes the flag bits to be set field by field, and every flagged write must still carry a legal BCD value, or the write is dropped. The stimulus therefore rewrites one field at a time with bit 7 added on top of a valid value. After each change, it fires a pair of strobes: one with a time that differs only in the newly ignored field, which must interrupt, and one that differs in the next field still compared, which must not.

// File: rtl/alarm_match.sv
module alarm_match (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] now_sec,
  input  logic [7:0] now_min,
  input  logic [7:0] now_hour,
  input  logic [7:0] now_date,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);

  logic [7:0] al_sec, al_min, al_hour, al_date;

  logic [3:0] units;
  assign units = reg_wdata[3:0];

  logic ok_ms, ok_hr, ok_dt;
  assign ok_ms = (units <= 4'd9) && (reg_wdata[6:4] <= 3'd5);
  assign ok_hr = (units <= 4'd9) &&
                 ((reg_wdata[5:4] < 2'd2) || (reg_wdata[5:4] == 2'd2 && units <= 4'd3));
  assign ok_dt = (units <= 4'd9) && !(reg_wdata[5:4] == 2'd0 && units == 4'd0) &&
                 ((reg_wdata[5:4] < 2'd3) || units <= 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_sec  <= 8'h00;
      al_min  <= 8'h00;
      al_hour <= 8'h00;
      al_date <= 8'h00;
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0: if (ok_ms) al_sec  <= reg_wdata;
        2'd1: if (ok_ms) al_min  <= reg_wdata;
        2'd2: if (ok_hr) al_hour <= reg_wdata;
        default: if (ok_dt) al_date <= reg_wdata;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = al_sec;
      2'd1:    reg_rdata = al_min;
      2'd2:    reg_rdata = al_hour;
      default: reg_rdata = al_date;
    endcase
  end

  logic eq_s, eq_m, eq_h, eq_d;
  assign eq_s = al_sec[6:0]  == now_sec[6:0];
  assign eq_m = al_min[6:0]  == now_min[6:0];
  assign eq_h = al_hour[5:0] == now_hour[5:0];
  assign eq_d = al_date[5:0] == now_date[5:0];

  logic [3:0] flags;
  assign flags = {al_date[7], al_hour[7], al_min[7], al_sec[7]};

  logic hit;
  always_comb begin
    case (flags)
      4'b0000: hit = eq_d && eq_h && eq_m && eq_s;
      4'b1000: hit = eq_h && eq_m && eq_s;
      4'b1100: hit = eq_m && eq_s;
      4'b1110: hit = eq_s;
      default: hit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= tick && hit;
  end

  a_r3_sec_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && !ok_ms) |=> $stable(al_sec));
  a_r4_hour_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && !ok_hr) |=> $stable(al_hour));
  a_r5_date_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3 && !ok_dt) |=> $stable(al_date));
  a_r11_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick));
  a_r6_full_match: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && flags == 4'b0000 && eq_s && eq_m && eq_h && eq_d) |=> irq);
  a_r10_every_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && flags != 4'b0000 && flags != 4'b1000 && flags != 4'b1100 && flags != 4'b1110) |=> irq);

endmodule

// File: tb/alarm_match_tb.sv
module alarm_match_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, reg_wr = 1'b0;
  logic [7:0] now_sec = 0, now_min = 0, now_hour = 0, now_date = 0, reg_wdata = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit exp_q[$];
  string tag_q[$];
  logic seen = 1'b0;

  always #4 clk = ~clk;

  alarm_match dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .now_sec(now_sec),
    .now_min(now_min), .now_hour(now_hour), .now_date(now_date), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always @(posedge clk) seen <= tick;

  always @(negedge clk) begin
    if (rst_n) begin
      if (seen && exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (irq !== e) begin
          errors++;
          $display("FAIL %s irq got %b exp %b", t, irq, e);
        end
      end else if (!seen) begin
        checks++;
        if (irq !== 1'b0) begin
          errors++;
          $display("FAIL R11 irq got %b exp 0 without tick", irq);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== e) begin
      errors++;
      $display("FAIL %s rdata[%0d] got %h exp %h", t, a, reg_rdata, e);
    end
  endtask

  task automatic strobe(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                        input logic [7:0] d, input bit e, input string t);
    @(negedge clk);
    now_sec = s; now_min = m; now_hour = h; now_date = d;
    exp_q.push_back(e);
    tag_q.push_back(t);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) rd(i[1:0], 8'h00, "R1 reset");
    @(negedge clk);
    checks++;
    if (irq !== 1'b0) begin errors++; $display("FAIL R1 irq got %b exp 0", irq); end

    wr(0, 8'h30); rd(0, 8'h30, "R2 sec write");
    wr(0, 8'h60); rd(0, 8'h30, "R3 sec 60 rejected");
    wr(0, 8'h5A); rd(0, 8'h30, "R3 sec bad digit rejected");
    wr(1, 8'h59); rd(1, 8'h59, "R3 min 59 accepted");
    wr(1, 8'h75); rd(1, 8'h59, "R3 min 75 rejected");
    wr(2, 8'h23); rd(2, 8'h23, "R4 hour 23 accepted");
    wr(2, 8'h24); rd(2, 8'h23, "R4 hour 24 rejected");
    wr(3, 8'h31); rd(3, 8'h31, "R5 date 31 accepted");
    wr(3, 8'h00); rd(3, 8'h31, "R5 date 00 rejected");
    wr(3, 8'h32); rd(3, 8'h31, "R5 date 32 rejected");

    strobe(8'h30, 8'h59, 8'h23, 8'h31, 1, "R6 full match");
    strobe(8'h30, 8'h59, 8'h23, 8'h30, 0, "R6 date differs");

    wr(3, 8'hB1); rd(3, 8'hB1, "R2 flag bit stored");
    strobe(8'h30, 8'h59, 8'h23, 8'h05, 1, "R7 date ignored");
    strobe(8'h30, 8'h59, 8'h22, 8'h31, 0, "R7 hour differs");

    wr(2, 8'hA3);
    strobe(8'h30, 8'h59, 8'h01, 8'h05, 1, "R8 hour ignored");
    strobe(8'h30, 8'h58, 8'h23, 8'h31, 0, "R8 min differs");

    wr(1, 8'hD9);
    strobe(8'h30, 8'h00, 8'h01, 8'h05, 1, "R9 min ignored");
    strobe(8'h31, 8'h59, 8'h23, 8'h31, 0, "R9 sec differs");

    wr(0, 8'hB0);
    strobe(8'h12, 8'h34, 8'h05, 8'h07, 1, "R10 all flags");

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    wr(0, 8'hB0);
    strobe(8'h00, 8'h01, 8'h02, 8'h03, 1, "R10 sec flag only");
    wr(0, 8'h00);
    strobe(8'h00, 8'h00, 8'h00, 8'h01, 0, "R6 reset date mismatch");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule